// File: doc/BRIEF.md
# Dual-Issue Pairing Check Unit

This unit sits at the issue point of an in-order core that has two execution pipes. The first pipe (U) can run every operation. The second pipe (V) accepts only a restricted set. Each cycle the unit looks at the two oldest decoded instructions at the head of the decode queue, slot 0 (older) and slot 1 (younger). It decides whether both leave together, with slot 0 going to U and slot 1 going to V, or whether slot 0 leaves alone on U.

The unit also reports how many entries the queue must drop. When the pair is refused, slot 1 stays in the queue and becomes slot 0 on the next cycle, where it may pair with the instruction behind it.

The queue head behaves like a stream source and the pipes like its sink. `slot0_valid` and `slot1_valid` say which head entries hold instructions, and slot 1 is only meaningful when slot 0 is valid. The `stall` input is the downstream back-pressure. While it is high nothing issues, the advance count is zero and the queue holds its contents. The decision is combinational, so an instruction is consumed in the same cycle its issue strobe is high.

Top module: `pair_issue_ctl`

## Requirements
- R1: When `stall` is 1 or `slot0_valid` is 0, `issue_u`, `issue_v` and `adv_cnt` are all 0.
- R2: With `stall` 0, `slot0_valid` 1 and `slot1_valid` 0, the unit gives `issue_u`=1, `issue_v`=0 and `adv_cnt`=1.
- R3: A pair is refused unless both slots have their `simple` flag set (no microcode sequencing).
- R4: A pair is refused when slot 0 is any jump, meaning its `jump` or `cjmp` flag is set.
- R5: A pair is refused when slot 0 writes a register (`s0_dst_en`=1) that slot 1 reads through an enabled source field (`s1_sa_en`/`s1_sa` or `s1_sb_en`/`s1_sb`).
- R6: A pair is refused when both slots write the same register. A slot whose destination enable is 0 never causes a destination conflict.
- R7: A slot 0 that sets condition codes may pair with a slot 1 conditional jump. The flag dependence does not block the pair.
- R8: A pair is refused when slot 1 has `u_only` set, so such an instruction never issues on V. A `u_only` instruction in slot 0 may still pair.
- R9: With both slots valid and no stall, a pair gives `issue_u`=1, `issue_v`=1 and `adv_cnt`=2. Any refused pair gives `issue_u`=1, `issue_v`=0 and `adv_cnt`=1. `adv_cnt` always equals `issue_u`+`issue_v`.
- R10: `issue_v` is never 1 unless `issue_u` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| stall | input | 1 | Downstream back-pressure, blocks all issue |
| slot0_valid | input | 1 | Older head entry present |
| s0_simple | input | 1 | Older needs no microcode |
| s0_jump | input | 1 | Older is an unconditional jump |
| s0_cjmp | input | 1 | Older is a conditional jump |
| s0_sets_cc | input | 1 | Older writes condition codes |
| s0_u_only | input | 1 | Older needs a U-only resource |
| s0_dst_en | input | 1 | Older writes a register |
| s0_dst | input | REG_W | Older destination register |
| s0_sa_en | input | 1 | Older source A used |
| s0_sa | input | REG_W | Older source A register |
| s0_sb_en | input | 1 | Older source B used |
| s0_sb | input | REG_W | Older source B register |
| slot1_valid | input | 1 | Younger head entry present |
| s1_simple | input | 1 | Younger needs no microcode |
| s1_jump | input | 1 | Younger is an unconditional jump |
| s1_cjmp | input | 1 | Younger is a conditional jump |
| s1_sets_cc | input | 1 | Younger writes condition codes |
| s1_u_only | input | 1 | Younger needs a U-only resource |
| s1_dst_en | input | 1 | Younger writes a register |
| s1_dst | input | REG_W | Younger destination register |
| s1_sa_en | input | 1 | Younger source A used |
| s1_sa | input | REG_W | Younger source A register |
| s1_sb_en | input | 1 | Younger source B used |
| s1_sb | input | REG_W | Younger source B register |
| issue_u | output | 1 | Slot 0 issues to U this cycle |
| issue_v | output | 1 | Slot 1 issues to V this cycle |
| adv_cnt | output | 2 | Entries the queue drops this cycle |

## Verification
Directed patterns each break one pairing rule while every other rule is met. This separates a refusal caused by simplicity, a jump in slot 0, a read-after-write, a write-after-write or a U-only younger from the cases where a pair should go through: a condition-code producer followed by a conditional jump, an older with no destination, and a U-only older. Stall and empty-slot patterns tell apart the case where nothing may move from a single issue. A queue-driven random stream then feeds the head from a model queue and pops it by the model's expected count. This exercises the slide-forward of a refused younger into slot 0 with its successor, and compares all three outputs on every clock.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef struct packed {
    logic simple;
    logic jump;
    logic cjmp;
    logic sets_cc;
    logic u_only;
  } op_flags_t;

  typedef enum logic [1:0] {
    ADV_NONE = 2'd0,
    ADV_ONE  = 2'd1,
    ADV_TWO  = 2'd2
  } adv_e;
endpackage

// File: rtl/pair_regdep.sv
module pair_regdep #(
  parameter int REG_W = 3,
  parameter int NSRC  = 2
) (
  input  logic                        old_dst_en,
  input  logic [REG_W-1:0]            old_dst,
  input  logic                        yng_dst_en,
  input  logic [REG_W-1:0]            yng_dst,
  input  logic [NSRC-1:0]             yng_src_en,
  input  logic [NSRC-1:0][REG_W-1:0]  yng_src,
  output logic                        raw_hit,
  output logic                        waw_hit
);
  logic [NSRC-1:0] src_match;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_match[g] = yng_src_en[g] && (yng_src[g] == old_dst);
  end

  assign raw_hit = old_dst_en && (|src_match);
  assign waw_hit = old_dst_en && yng_dst_en && (yng_dst == old_dst);
endmodule

// File: rtl/pair_rules.sv
module pair_rules
  import pair_pkg::*;
(
  input  op_flags_t old_f,
  input  op_flags_t yng_f,
  output logic      class_ok,
  output logic      cc_bypass
);
  logic both_simple;
  logic old_branch;
  logic unused_flags;

  assign both_simple = old_f.simple && yng_f.simple;
  assign old_branch  = old_f.jump || old_f.cjmp;
  // flag dependence producer->conditional jump is deliberately not a blocker
  assign cc_bypass   = old_f.sets_cc && yng_f.cjmp;
  assign class_ok    = both_simple && !old_branch && !yng_f.u_only;
  assign unused_flags = ^{old_f.u_only, yng_f.jump, yng_f.sets_cc};
endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
  import pair_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             slot0_valid,
  input  logic             s0_simple,
  input  logic             s0_jump,
  input  logic             s0_cjmp,
  input  logic             s0_sets_cc,
  input  logic             s0_u_only,
  input  logic             s0_dst_en,
  input  logic [REG_W-1:0] s0_dst,
  input  logic             s0_sa_en,
  input  logic [REG_W-1:0] s0_sa,
  input  logic             s0_sb_en,
  input  logic [REG_W-1:0] s0_sb,
  input  logic             slot1_valid,
  input  logic             s1_simple,
  input  logic             s1_jump,
  input  logic             s1_cjmp,
  input  logic             s1_sets_cc,
  input  logic             s1_u_only,
  input  logic             s1_dst_en,
  input  logic [REG_W-1:0] s1_dst,
  input  logic             s1_sa_en,
  input  logic [REG_W-1:0] s1_sa,
  input  logic             s1_sb_en,
  input  logic [REG_W-1:0] s1_sb,
  output logic             issue_u,
  output logic             issue_v,
  output logic [1:0]       adv_cnt
);
  localparam int NSRC = 2;

  op_flags_t old_f, yng_f;
  logic      class_ok, cc_bypass, raw_hit, waw_hit, pair_ok;
  logic [NSRC-1:0]            y_src_en;
  logic [NSRC-1:0][REG_W-1:0] y_src;
  adv_e      adv;
  logic      unused_old_src;

  assign old_f = '{simple: s0_simple, jump: s0_jump, cjmp: s0_cjmp,
                   sets_cc: s0_sets_cc, u_only: s0_u_only};
  assign yng_f = '{simple: s1_simple, jump: s1_jump, cjmp: s1_cjmp,
                   sets_cc: s1_sets_cc, u_only: s1_u_only};
  assign y_src_en = {s1_sb_en, s1_sa_en};
  assign y_src    = {s1_sb, s1_sa};
  assign unused_old_src = ^{s0_sa_en, s0_sa, s0_sb_en, s0_sb};

  pair_rules u_rules (
    .old_f    (old_f),
    .yng_f    (yng_f),
    .class_ok (class_ok),
    .cc_bypass(cc_bypass)
  );

  pair_regdep #(.REG_W(REG_W), .NSRC(NSRC)) u_regdep (
    .old_dst_en(s0_dst_en),
    .old_dst   (s0_dst),
    .yng_dst_en(s1_dst_en),
    .yng_dst   (s1_dst),
    .yng_src_en(y_src_en),
    .yng_src   (y_src),
    .raw_hit   (raw_hit),
    .waw_hit   (waw_hit)
  );

  assign pair_ok = slot1_valid && class_ok && !raw_hit && !waw_hit;

  always_comb begin
    if (stall || !slot0_valid) adv = ADV_NONE;
    else if (pair_ok)          adv = ADV_TWO;
    else                       adv = ADV_ONE;
  end

  assign adv_cnt = adv;
  assign issue_u = (adv != ADV_NONE);
  assign issue_v = (adv == ADV_TWO);

  // R1
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !slot0_valid) |-> (!issue_u && !issue_v && adv_cnt == 2'd0));
  // R9
  adv_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_cnt == ({1'b0, issue_u} + {1'b0, issue_v}));
  // R10
  v_needs_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> issue_u);
  // R4
  no_jump_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> (!s0_jump && !s0_cjmp));
  // R8
  u_only_not_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> !s1_u_only);
  // R5
  raw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_v && s0_dst_en) |-> (!(s1_sa_en && s1_sa == s0_dst) &&
                                !(s1_sb_en && s1_sb == s0_dst)));
  // R6
  waw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_v && s0_dst_en && s1_dst_en) |-> (s1_dst != s0_dst));
  // R7
  cc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_bypass && !stall && slot0_valid && slot1_valid && s0_simple && s1_simple
     && !s0_jump && !s0_cjmp && !s1_u_only && !s0_dst_en) |-> issue_v);
endmodule

// File: tb/test_pair_issue_ctl.sv
module test_pair_issue_ctl;
  localparam int RW = 3;

  typedef struct packed {
    logic simple, jump, cjmp, sets_cc, u_only;
    logic dst_en; logic [RW-1:0] dst;
    logic sa_en;  logic [RW-1:0] sa;
    logic sb_en;  logic [RW-1:0] sb;
  } ins_t;

  logic clk = 0, rst_n = 0, stall = 0, v0 = 0, v1 = 0;
  ins_t a = '0, b = '0;
  logic iu, iv;
  logic [1:0] adv;
  int checks = 0, fails = 0;
  bit done = 0;
  ins_t q[$];

  always #4 clk = ~clk;

  pair_issue_ctl #(.REG_W(RW)) i_pair_issue_ctl (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .slot0_valid(v0), .s0_simple(a.simple), .s0_jump(a.jump), .s0_cjmp(a.cjmp),
    .s0_sets_cc(a.sets_cc), .s0_u_only(a.u_only), .s0_dst_en(a.dst_en),
    .s0_dst(a.dst), .s0_sa_en(a.sa_en), .s0_sa(a.sa), .s0_sb_en(a.sb_en), .s0_sb(a.sb),
    .slot1_valid(v1), .s1_simple(b.simple), .s1_jump(b.jump), .s1_cjmp(b.cjmp),
    .s1_sets_cc(b.sets_cc), .s1_u_only(b.u_only), .s1_dst_en(b.dst_en),
    .s1_dst(b.dst), .s1_sa_en(b.sa_en), .s1_sa(b.sa), .s1_sb_en(b.sb_en), .s1_sb(b.sb),
    .issue_u(iu), .issue_v(iv), .adv_cnt(adv)
  );

  function automatic ins_t alu(int d, int s1, int s2);
    ins_t t = '0;
    t.simple = 1;
    t.dst_en = (d >= 0);  t.dst = RW'(d < 0 ? 0 : d);
    t.sa_en  = (s1 >= 0); t.sa  = RW'(s1 < 0 ? 0 : s1);
    t.sb_en  = (s2 >= 0); t.sb  = RW'(s2 < 0 ? 0 : s2);
    return t;
  endfunction

  function automatic int model(bit st, bit x0, bit x1, ins_t o, ins_t y);
    bit ok;
    if (st || !x0) return 0;
    if (!x1) return 1;
    ok = o.simple && y.simple && !o.jump && !o.cjmp && !y.u_only;
    if (o.dst_en) begin
      if (y.sa_en && y.sa == o.dst) ok = 0;
      if (y.sb_en && y.sb == o.dst) ok = 0;
      if (y.dst_en && y.dst == o.dst) ok = 0;
    end
    return ok ? 2 : 1;
  endfunction

  task automatic cmp(string tag, int exp_adv);
    checks++;
    if (adv != 2'(exp_adv) || iu != (exp_adv >= 1) || iv != (exp_adv == 2)) begin
      fails++;
      $display("FAIL %s: got u=%0b v=%0b adv=%0d, expected u=%0b v=%0b adv=%0d",
               tag, iu, iv, adv, exp_adv >= 1, exp_adv == 2, exp_adv);
    end
  endtask

  task automatic apply(string tag, bit st, bit x0, bit x1, ins_t o, ins_t y, int exp_adv);
    @(negedge clk);
    stall = st; v0 = x0; v1 = x1; a = o; b = y;
    #2;
    cmp(tag, exp_adv);
    if (model(st, x0, x1, o, y) != exp_adv) begin
      fails++; checks++;
      $display("FAIL %s: model table mismatch got %0d expected %0d",
               tag, model(st, x0, x1, o, y), exp_adv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    ins_t t0, t1;
    repeat (3) @(posedge clk);
    #2;
    cmp("R1 reset state", 0);
    rst_n = 1;

    apply("R1 stall", 1, 1, 1, alu(1, 2, 3), alu(4, 5, 6), 0);
    apply("R1 empty slot0", 0, 0, 0, alu(1, 2, 3), alu(4, 5, 6), 0);
    apply("R2 single", 0, 1, 0, alu(1, 2, 3), alu(4, 5, 6), 1);
    apply("R9 clean pair", 0, 1, 1, alu(1, 2, 3), alu(4, 5, 6), 2);
    t1 = alu(4, 5, 6); t1.simple = 0;
    apply("R3 younger complex", 0, 1, 1, alu(1, 2, 3), t1, 1);
    t0 = alu(1, 2, 3); t0.simple = 0;
    apply("R3 older complex", 0, 1, 1, t0, alu(4, 5, 6), 1);
    t0 = alu(-1, 2, -1); t0.jump = 1;
    apply("R4 older jump", 0, 1, 1, t0, alu(4, 5, 6), 1);
    t0 = alu(-1, 2, -1); t0.cjmp = 1;
    apply("R4 older cond jump", 0, 1, 1, t0, alu(4, 5, 6), 1);
    apply("R5 raw src A", 0, 1, 1, alu(3, 1, 2), alu(4, 3, 6), 1);
    apply("R5 raw src B", 0, 1, 1, alu(3, 1, 2), alu(4, 5, 3), 1);
    t1 = alu(4, 3, 6); t1.sa_en = 0;
    apply("R5 disabled source", 0, 1, 1, alu(3, 1, 2), t1, 2);
    apply("R6 waw", 0, 1, 1, alu(5, 1, 2), alu(5, 6, 7), 1);
    apply("R6 older no dst", 0, 1, 1, alu(-1, 5, 6), alu(5, 5, 7), 2);
    t0 = alu(2, 1, 3); t0.sets_cc = 1;
    t1 = alu(-1, -1, -1); t1.cjmp = 1;
    apply("R7 cc pair", 0, 1, 1, t0, t1, 2);
    t1 = alu(4, 5, 6); t1.u_only = 1;
    apply("R8 younger u-only", 0, 1, 1, alu(1, 2, 3), t1, 1);
    t0 = alu(1, 2, 3); t0.u_only = 1;
    apply("R8 older u-only", 0, 1, 1, t0, alu(4, 5, 6), 2);
    t1 = alu(4, 5, 6); t1.jump = 1; t1.dst_en = 0;
    apply("R10 younger jump", 0, 1, 1, alu(1, 2, 3), t1, 2);

    // random stream: model queue popped by expected count
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int e;
      while (q.size() < 4 && ($urandom % 4 != 0)) begin
        ins_t n;
        n = ins_t'($urandom);
        n.simple = ($urandom % 5 != 0);
        n.u_only = ($urandom % 6 == 0);
        n.jump   = ($urandom % 8 == 0);
        n.cjmp   = !n.jump && ($urandom % 6 == 0);
        q.push_back(n);
      end
      @(negedge clk);
      stall = ($urandom % 8 == 0);
      v0 = (q.size() > 0); v1 = (q.size() > 1);
      a = v0 ? q[0] : '0; b = v1 ? q[1] : '0;
      #2;
      e = model(stall, v0, v1, a, b);
      cmp("R9 stream", e);
      for (int k = 0; k < e; k++) void'(q.pop_front());
    end
    finish_run();
  end
endmodule